// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Sequencer

This block turns single bus reads that fall inside a chip's address window into complete read transactions on a serial flash bus. The upper bits of the read address choose one of several flash chips, and the lower bits give the byte offset within that chip's window. For each accepted read the block selects the chip and shifts out a command opcode, then the offset, then any dummy bytes. It then clocks in one to four data bytes. These are packed into a 32-bit read word, and a one-cycle ready strobe is returned.

Each chip has its own 32-bit control word and its own wide-addressing flag, both supplied from outside. The control word gives the access mode, the opcode and the dummy-byte count. The wide-addressing flag chooses between three and four address bytes. Only the two read modes, normal and fast, start a flash transaction. A read aimed at a chip in another mode, or at a chip index with no chip behind it, is answered at once with a zero word and leaves the flash bus idle.

Top module: `spi_flash_rd_seq`

## Requirements
- R1: During and right after reset, every chip select is high, the serial clock is low, ready is low and the read word is zero.
- R2: The chip index is the address bits above the window width. While a transaction runs, only that chip's select is low, and it stays low from the first byte to the last.
- R3: The first byte on the data-out line is the opcode held in bits 23:16 of the selected chip's control word, sent MSB first.
- R4: When the chip's wide-addressing flag is 0, the opcode is followed by the low 24 bits of the window offset as three bytes, most significant byte first. This is the opcode and address together as one 32-bit word.
- R5: When the chip's wide-addressing flag is 1, the opcode is followed by the 32-bit zero-extended window offset as four bytes, most significant byte first.
- R6: Control bits 1:0 give the mode: 0 is normal read and 1 is fast read. Normal read inserts no dummy bytes, whatever the dummy field holds. Fast read inserts the number of dummy bytes given by the 3-bit field {bit 14, bits 7:6}, so bit 14 is the top bit. The data-out line is held high through the dummy and data bytes.
- R7: The block reads rd_size+1 data bytes, where rd_size is 0 to 3. The first byte received goes to bits 7:0 of rd_data, the next to bits 15:8, and so on. Bytes that were not read are zero.
- R8: The serial clock runs in mode 0 at half the system clock, with 16 system cycles per byte and no gap between bytes. For a frame of B bytes, ready is high in exactly one cycle, which comes 16*B+1 clock edges after the edge that accepted the request. The chip select is already high in that cycle.
- R9: A request is rejected when the selected chip is in mode 2 or 3, or when the chip index is not below the chip count. A rejected request drives no chip select and raises ready in the cycle after it is taken, with rd_data equal to zero.
- R10: A request that arrives while a transaction is in progress is ignored. It neither selects another chip nor starts a second transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | One-cycle read request |
| rd_addr | input | WIN_LG+CS_W | Read address: chip index above, window offset below |
| rd_size | input | 2 | Number of data bytes minus one |
| rd_data | output | 32 | Assembled little-endian read word |
| rd_ready | output | 1 | One-cycle strobe: rd_data is valid |
| ctl_words | input | NUM_CS*32 | Per-chip control words, chip i in bits 32*i+31:32*i |
| wide_addr | input | NUM_CS | Per-chip 4-byte addressing enable |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench builds the block with NUM_CS=3 and WIN_LG=12. With three chips behind a 2-bit chip index, index 3 exists in the address but has no chip, so the reject path for a missing chip can be reached. The 12-bit window keeps the offsets small enough to sweep while still filling two address bytes. The sweep covers every chip, both address widths, normal mode and all eight dummy counts of fast mode, with the read size rotating through all four values. This reaches both the shortest frame (5 bytes) and the longest (16 bytes).

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } sfr_state_e;

  localparam logic [1:0] MODE_NORMAL = 2'd0;
  localparam logic [1:0] MODE_FAST   = 2'd1;

  // command byte field of a control word
  function automatic logic [7:0] ctl_opcode(input logic [31:0] c);
    return c[23:16];
  endfunction

  // split dummy field: bit 14 is the top bit, bits 7:6 the low pair
  function automatic logic [2:0] ctl_dummy_field(input logic [31:0] c);
    return {c[14], c[7:6]};
  endfunction

  function automatic logic ctl_is_read(input logic [31:0] c);
    return (c[1:0] == MODE_NORMAL) || (c[1:0] == MODE_FAST);
  endfunction

  // dummy bytes actually inserted: only fast read uses the field
  function automatic logic [2:0] dummy_bytes(input logic [31:0] c);
    return (c[1:0] == MODE_FAST) ? ctl_dummy_field(c) : 3'd0;
  endfunction

  function automatic logic [4:0] addr_bytes(input logic wide);
    return wide ? 5'd4 : 5'd3;
  endfunction

  // opcode + address + dummies
  function automatic logic [4:0] header_bytes(input logic wide, input logic [2:0] dum);
    return 5'd1 + addr_bytes(wide) + {2'b00, dum};
  endfunction

  function automatic logic [4:0] frame_bytes(input logic [4:0] hdr, input logic [1:0] size);
    return hdr + {3'b000, size} + 5'd1;
  endfunction

  // k-th address byte on the wire (k = 0 first), most significant first
  function automatic logic [7:0] addr_byte(input logic [31:0] off, input logic wide,
                                           input logic [2:0] k);
    logic [1:0] sel;
    sel = wide ? 2'(3 - k) : 2'(2 - k);
    return 8'(off >> {sel, 3'b000});
  endfunction

endpackage

// File: rtl/sfr_chip_sel.sv
module sfr_chip_sel #(
  parameter int NUM_CS = 2,
  parameter int CS_W   = 1
) (
  input  logic [CS_W-1:0]       cs_idx,
  input  logic [NUM_CS*32-1:0]  ctl_words,
  input  logic [NUM_CS-1:0]     wide_addr,
  output logic [31:0]           ctl_word,
  output logic                  wide,
  output logic                  present
);

  always_comb begin
    ctl_word = 32'd0;
    wide     = 1'b0;
    present  = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (cs_idx == CS_W'(i)) begin
        ctl_word = ctl_words[32*i +: 32];
        wide     = wide_addr[i];
        present  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sfr_frame_src.sv
module sfr_frame_src
  import sfr_pkg::*;
(
  input  logic [4:0]  idx,
  input  logic [7:0]  opcode,
  input  logic [31:0] offset,
  input  logic        wide,
  output logic [7:0]  tx_byte
);

  logic [4:0] ab;
  assign ab = addr_bytes(wide);

  always_comb begin
    if (idx == 5'd0)
      tx_byte = opcode;
    else if (idx <= ab)
      tx_byte = addr_byte(offset, wide, 3'(idx - 5'd1));
    else
      tx_byte = 8'hFF;
  end

endmodule

// File: rtl/sfr_bit_engine.sv
module sfr_bit_engine #(
  parameter  int BITS  = 8,
  localparam int CNT_W = $clog2(2 * BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BITS-1:0] tx_byte,
  input  logic            miso,
  output logic            busy,
  output logic            last,
  output logic [BITS-1:0] rx_byte,
  output logic            sck,
  output logic            mosi
);

  logic [CNT_W-1:0] cnt;
  logic [BITS-1:0]  shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt   <= '0;
      shreg <= tx_byte;
    end else if (busy) begin
      if (cnt[0]) shreg <= {shreg[BITS-2:0], miso};
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(2 * BITS - 1)) busy <= 1'b0;
    end
  end

  assign last    = busy && (cnt == CNT_W'(2 * BITS - 1));
  assign rx_byte = {shreg[BITS-2:0], miso};
  assign sck     = busy && cnt[0];
  assign mosi    = busy ? shreg[BITS-1] : 1'b1;

  AST_MOSI_HELD_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt[0]) |-> $stable(mosi)); // R8
  AST_SCK_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck); // R8

endmodule

// File: rtl/spi_flash_rd_seq.sv
module spi_flash_rd_seq
  import sfr_pkg::*;
#(
  parameter  int NUM_CS = 2,
  parameter  int WIN_LG = 26,
  localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int ADDR_W = WIN_LG + CS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_req,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [1:0]           rd_size,
  output logic [31:0]          rd_data,
  output logic                 rd_ready,
  input  logic [NUM_CS*32-1:0] ctl_words,
  input  logic [NUM_CS-1:0]    wide_addr,
  output logic [NUM_CS-1:0]    spi_cs_n,
  output logic                 spi_sck,
  output logic                 spi_mosi,
  input  logic                 spi_miso
);

  // request decode
  logic [CS_W-1:0] req_cs;
  logic [31:0]     req_off;
  logic [31:0]     sel_ctl;
  logic            sel_wide;
  logic            sel_present;
  logic            req_accept;
  logic            req_reject;

  assign req_cs  = rd_addr[ADDR_W-1:WIN_LG];
  assign req_off = {{(32 - WIN_LG){1'b0}}, rd_addr[WIN_LG-1:0]};

  sfr_chip_sel #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_sel (
    .cs_idx    (req_cs),
    .ctl_words (ctl_words),
    .wide_addr (wide_addr),
    .ctl_word  (sel_ctl),
    .wide      (sel_wide),
    .present   (sel_present)
  );

  sfr_state_e      state;
  logic [CS_W-1:0] cs_q;
  logic [31:0]     off_q;
  logic            wide_q;
  logic [7:0]      opc_q;
  logic [4:0]      hdr_q;
  logic [4:0]      total_q;
  logic [4:0]      cur;
  logic [31:0]     rdata_q;

  assign req_accept = rd_req && (state == ST_IDLE) && sel_present && ctl_is_read(sel_ctl);
  assign req_reject = rd_req && (state == ST_IDLE) && !(sel_present && ctl_is_read(sel_ctl));

  // byte sequencing events
  logic       eng_busy;
  logic       eng_last;
  logic [7:0] eng_rx;
  logic       issue_first;
  logic       last_byte;
  logic       eng_start;
  logic [4:0] src_idx;
  logic [7:0] src_byte;
  logic       is_data;
  logic [4:0] slot;

  assign issue_first = (state == ST_XFER) && !eng_busy;
  assign last_byte   = (cur == total_q - 5'd1);
  assign eng_start   = issue_first || ((state == ST_XFER) && eng_last && !last_byte);
  assign src_idx     = issue_first ? cur : cur + 5'd1;
  assign is_data     = (cur >= hdr_q);
  assign slot        = cur - hdr_q;

  sfr_frame_src u_src (
    .idx     (src_idx),
    .opcode  (opc_q),
    .offset  (off_q),
    .wide    (wide_q),
    .tx_byte (src_byte)
  );

  sfr_bit_engine #(.BITS(8)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eng_start),
    .tx_byte (src_byte),
    .miso    (spi_miso),
    .busy    (eng_busy),
    .last    (eng_last),
    .rx_byte (eng_rx),
    .sck     (spi_sck),
    .mosi    (spi_mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cs_q    <= '0;
      off_q   <= '0;
      wide_q  <= 1'b0;
      opc_q   <= '0;
      hdr_q   <= '0;
      total_q <= '0;
      cur     <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_accept) begin
            cs_q    <= req_cs;
            off_q   <= req_off;
            wide_q  <= sel_wide;
            opc_q   <= ctl_opcode(sel_ctl);
            hdr_q   <= header_bytes(sel_wide, dummy_bytes(sel_ctl));
            total_q <= frame_bytes(header_bytes(sel_wide, dummy_bytes(sel_ctl)), rd_size);
            cur     <= '0;
            rdata_q <= '0;
            state   <= ST_XFER;
          end else if (req_reject) begin
            rdata_q <= '0;
            state   <= ST_DONE;
          end
        end
        ST_XFER: begin
          if (eng_last) begin
            for (int k = 0; k < 4; k++) begin
              if (is_data && (slot == 5'(k))) rdata_q[8*k +: 8] <= eng_rx;
            end
            if (last_byte) state <= ST_DONE;
            else           cur   <= cur + 5'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign spi_cs_n[g] = !((state == ST_XFER) && (cs_q == CS_W'(g)));
  end

  assign rd_data  = rdata_q;
  assign rd_ready = (state == ST_DONE);

  AST_ONE_CHIP_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n)); // R2
  AST_CS_STEADY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_XFER) && $past(state == ST_XFER)) |-> $stable(spi_cs_n)); // R10
  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (&spi_cs_n) |-> !spi_sck); // R8
  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> !rd_ready); // R8
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |=> (rd_ready && (&spi_cs_n) && (rd_data == 32'd0))); // R9
  AST_READY_CS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (&spi_cs_n)); // R8

endmodule

// File: tb/sim_spi_flash_rd_seq.sv
module sim_spi_flash_rd_seq;
  localparam int NCS = 3;
  localparam int WLG = 12;
  localparam int AW  = WLG + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            rd_req = 1'b0;
  logic [AW-1:0]   rd_addr = '0;
  logic [1:0]      rd_size = '0;
  logic [31:0]     rd_data;
  logic            rd_ready;
  logic [NCS*32-1:0] ctl_words = '0;
  logic [NCS-1:0]  wide_addr = '0;
  logic [NCS-1:0]  spi_cs_n;
  logic            spi_sck;
  logic            spi_mosi;
  logic            spi_miso = 1'b0;

  spi_flash_rd_seq #(.NUM_CS(NCS), .WIN_LG(WLG)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_data(rd_data), .rd_ready(rd_ready), .ctl_words(ctl_words), .wide_addr(wide_addr),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;

  // expected transaction seen by the flash model
  int exp_cs = 0;
  int exp_off = 0;
  int exp_hdr = 4;

  // flash model state
  logic [255:0] capv = '0;
  int  rcount = 0;
  int  starts = 0;
  int  seen_mask = 0;
  logic prev_sck = 1'b0;
  logic prev_idle = 1'b1;

  function automatic logic [7:0] mem_byte(input int cs, input int off);
    return 8'((off * 7 + cs * 61 + 13) & 255);
  endfunction

  function automatic logic resp_bit(input int k);
    logic [7:0] b;
    if (k / 8 < exp_hdr) return 1'b1;
    b = mem_byte(exp_cs, exp_off + k / 8 - exp_hdr);
    return b[7 - (k % 8)];
  endfunction

  function automatic logic [7:0] cap_byte(input int j);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[7 - b] = capv[8 * j + b];
    return v;
  endfunction

  always @(negedge clk) begin
    if (!(&spi_cs_n)) begin
      if (prev_idle) begin
        starts++;
        rcount = 0;
        seen_mask = 0;
        prev_sck = 1'b0;
        spi_miso = resp_bit(0);
      end
      seen_mask = seen_mask | {29'd0, ~spi_cs_n};
      if (spi_sck && !prev_sck) begin
        if (rcount < 256) capv[rcount] = spi_mosi;
        rcount++;
      end else if (!spi_sck && prev_sck) begin
        spi_miso = resp_bit(rcount);
      end
      prev_sck = spi_sck;
      prev_idle = 1'b0;
    end else begin
      prev_idle = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic do_read(input int cs, input int off, input int size, input int mode,
                         input int dum, input int wide, input int opc,
                         input bit expect_ok, input int poke_at);
    int n, ab, d, nb, s0;
    logic [31:0] expd;
    logic [7:0]  eb;
    bit ok;
    string atag;
    if (cs < NCS) begin
      ctl_words[cs*32 +: 32] = {8'h00, 8'(opc), 1'b0, 1'(dum >> 2), 6'b0, 2'(dum),
                                4'b0, 2'(mode)};
      wide_addr[cs] = 1'(wide);
    end
    ab = (wide != 0) ? 4 : 3;
    d  = (mode == 1) ? dum : 0;
    exp_cs = cs; exp_off = off; exp_hdr = 1 + ab + d;
    nb = exp_hdr + size + 1;
    s0 = starts;
    @(negedge clk);
    rd_addr = AW'((cs << WLG) | off);
    rd_size = 2'(size);
    rd_req  = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) rd_req = 1'b0;
      if (poke_at != 0 && n == poke_at) begin
        rd_addr = AW'((((cs + 1) % NCS) << WLG) | 5);
        rd_req = 1'b1;
      end
      if (poke_at != 0 && n == poke_at + 1) rd_req = 1'b0;
    end while (!rd_ready && n < 4000);
    if (expect_ok) begin
      chk(n == 16 * nb + 2, "R8", "ready latency", 64'(n), 64'(16 * nb + 2));
      chk(starts == s0 + 1 && seen_mask == (1 << cs), "R2", "chip select set",
          64'(seen_mask), 64'(1 << cs));
      chk(rcount == 8 * nb, "R8", "serial clock count", 64'(rcount), 64'(8 * nb));
      chk(cap_byte(0) == 8'(opc), "R3", "opcode byte", 64'(cap_byte(0)), 64'(opc));
      ok = 1'b1;
      for (int k = 0; k < ab; k++) begin
        eb = 8'(off >> (8 * (ab - 1 - k)));
        if (cap_byte(1 + k) != eb) ok = 1'b0;
      end
      atag = (wide != 0) ? "R5" : "R4";
      chk(ok, atag, "address bytes", 64'(cap_byte(ab)), 64'(off & 255));
      ok = 1'b1;
      for (int j = 1 + ab; j < nb; j++) if (cap_byte(j) != 8'hFF) ok = 1'b0;
      chk(ok, "R6", "dummy and data-phase bytes", 64'(cap_byte(nb - 1)), 64'hFF);
      expd = '0;
      for (int i = 0; i <= size; i++) expd[8*i +: 8] = mem_byte(cs, off + i);
      chk(rd_data == expd, "R7", "read word", 64'(rd_data), 64'(expd));
    end else begin
      chk(n == 1 && starts == s0 && rd_data == 32'd0, "R9", "rejected request",
          64'(n), 64'd1);
    end
  endtask

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0, sz, off;
    ctl_words = {32'hFFFF_FFFF, 32'h1234_5678, 32'hA5A5_0001};
    repeat (4) @(negedge clk);
    chk(&spi_cs_n && !spi_sck && !rd_ready && rd_data == 0, "R1", "in reset",
        64'(spi_cs_n), 64'h7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(&spi_cs_n && !spi_sck && !rd_ready && rd_data == 0, "R1", "after reset",
        64'({spi_sck, rd_ready}), 64'h0);

    // sweep: chips, address widths, normal mode and every fast dummy count
    for (int cs = 0; cs < NCS; cs++) begin
      for (int w = 0; w < 2; w++) begin
        for (int dm = 0; dm < 9; dm++) begin
          sz  = (cs + w + dm) % 4;
          off = (cs * 1111 + dm * 397 + w * 2049 + 5) & 12'hFFF;
          if (dm == 0)
            do_read(cs, off, sz, 0, 5, w, 8'h03 + cs, 1'b1, 0);   // R6 field ignored
          else
            do_read(cs, off, sz, 1, dm - 1, w, 8'h0B + dm * 16 + cs, 1'b1, 0);
        end
      end
    end

    // extreme offsets
    do_read(2, 12'hFFC, 3, 1, 7, 1, 8'h0C, 1'b1, 0);
    do_read(0, 0, 0, 0, 0, 0, 8'h03, 1'b1, 0);

    // rejected requests: R9
    do_read(1, 12'h010, 1, 2, 0, 0, 8'h02, 1'b0, 0);
    do_read(1, 12'h020, 3, 3, 0, 1, 8'h02, 1'b0, 0);
    do_read(3, 12'h030, 2, 0, 0, 0, 8'h03, 1'b0, 0);

    // request during transfer is ignored: R10
    s0 = starts;
    do_read(0, 12'h123, 3, 1, 2, 0, 8'h0B, 1'b1, 40);
    chk(starts == s0 + 1 && seen_mask == 1, "R10", "no other chip during frame",
        64'(seen_mask), 64'd1);
    repeat (40) @(negedge clk);
    chk(starts == s0 + 1 && (&spi_cs_n) && !rd_ready, "R10", "no late transaction",
        64'(starts - s0), 64'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule